// File: doc/BRIEF.md
# Bidirectional Latched Byte Transceiver

This block moves a byte between two ports, A and B, in both directions without inverting it. Each direction owns its own bank of storage. The A-to-B bank is loaded from port A and drives port B. The B-to-A bank is loaded from port B and drives port A. Because the two banks are separate, a value can be parked in each direction at the same time and driven out later.

Each direction has three active-low controls:

- **Select** gates both the storage and the driver of that direction.
- **Latch** makes the storage follow its input while low, and holds it once it goes high.
- **Drive** enables the far port's driver.

The pads are split into input, output and output-enable vectors, so no tristate net is needed. A storage bank is a register clocked by the system clock. While a bank follows its input, the far port shows the input sampled one clock earlier. When latch rises, the bank keeps the last value sampled while latch was low.

The data pads carry no valid/ready handshake. They model pins that are driven or not driven, so there is nothing to back-pressure. All controls are plain pins.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While `rst_n` is low, both banks read zero on `port_b_out` and `port_a_out`, and both `port_a_oe` and `port_b_oe` are 0.
- R2: With `ab_sel_n`=0, `ab_lat_n`=0 and `port_a_oe`=0 at a clock edge, `port_b_out` after that edge equals the 8-bit `port_a_in` sampled at that edge, bit for bit and not inverted.
- R3: When `ab_lat_n` goes high, the A-to-B bank keeps the value it loaded at the last edge where `ab_lat_n` was low. Later changes on `port_a_in` leave `port_b_out` unchanged while `ab_lat_n` stays high.
- R4: With `ab_sel_n`=1, the A-to-B bank holds whatever `ab_lat_n` does, and `port_b_oe` is 0.
- R5: `port_b_oe` is 1 exactly when `ab_sel_n`=0 and `ab_drv_n`=0 (out of reset), and `port_a_oe` is 1 exactly when `ba_sel_n`=0 and `ba_drv_n`=0 (out of reset). `port_b_out` and `port_a_out` show the stored value whether or not the matching enable is 1.
- R6: `ab_drv_n` and `ba_drv_n` have no effect on loading or holding. A bank follows its input with its drive control high exactly as it does with it low.
- R7: The B-to-A direction behaves like R2 to R4, with `ba_sel_n`, `ba_lat_n` and `ba_drv_n`. It loads from `port_b_in` and shows its contents on `port_a_out`.
- R8: The two banks are independent. Values parked in both directions are held together and can be driven out on both ports at once.
- R9: At an edge where `port_a_oe` is 1, the A-to-B bank does not load. At an edge where `port_b_oe` is 1, the B-to-A bank does not load. This holds even if the bank is selected and its latch is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ab_sel_n | input | 1 | A-to-B select, active low |
| ab_lat_n | input | 1 | A-to-B latch: low follows, high holds |
| ab_drv_n | input | 1 | A-to-B drive enable, active low |
| ba_sel_n | input | 1 | B-to-A select, active low |
| ba_lat_n | input | 1 | B-to-A latch: low follows, high holds |
| ba_drv_n | input | 1 | B-to-A drive enable, active low |
| port_a_in | input | W (8) | Value seen on the A pads |
| port_a_out | output | W (8) | B-to-A bank contents |
| port_a_oe | output | 1 | Drive enable for the A pads |
| port_b_in | input | W (8) | Value seen on the B pads |
| port_b_out | output | W (8) | A-to-B bank contents |
| port_b_oe | output | 1 | Drive enable for the B pads |

## Verification
A wrong load condition or a wrong bank value shows on the far port's output one clock after the faulty edge. The bench therefore compares every output on every cycle against its reference and catches such a fault one cycle after it happens. A fault in the drive decode shows up in the same cycle, because the enables are combinational. The bench loops the driven pads back onto their inputs. A missing feedback block then shows as a bank that takes its own direction's loop-back data instead of holding.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Per-bank storage behaviour for the current cycle
  typedef enum logic [1:0] {
    LANE_OFF    = 2'd0,  // direction deselected: hold, no drive
    LANE_HOLD   = 2'd1,  // selected, latch closed or loop-back blocked
    LANE_FOLLOW = 2'd2   // selected and transparent: load every edge
  } lane_mode_e;

  localparam int unsigned NUM_DIRS = 2;
endpackage

// File: rtl/xcvr_lane_ctrl.sv
module xcvr_lane_ctrl
  import xcvr_pkg::*;
(
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       lat_n,
  input  logic       drv_n,
  input  logic       src_driven,  // the source pad is being driven by the other bank
  output lane_mode_e mode,
  output logic       drv_on
);
  always_comb begin
    if (sel_n)                    mode = LANE_OFF;
    else if (lat_n || src_driven) mode = LANE_HOLD;
    else                          mode = LANE_FOLLOW;
  end

  assign drv_on = rst_n & ~sel_n & ~drv_n;
endmodule

// File: rtl/xcvr_lane_store.sv
module xcvr_lane_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  lane_mode_e   mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   q <= '0;
    else if (mode == LANE_FOLLOW) q <= din;
  end
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ab_sel_n,
  input  logic         ab_lat_n,
  input  logic         ab_drv_n,
  input  logic         ba_sel_n,
  input  logic         ba_lat_n,
  input  logic         ba_drv_n,
  input  logic [W-1:0] port_a_in,
  output logic [W-1:0] port_a_out,
  output logic         port_a_oe,
  input  logic [W-1:0] port_b_in,
  output logic [W-1:0] port_b_out,
  output logic         port_b_oe
);
  // Index 0: A-to-B bank, index 1: B-to-A bank
  localparam int unsigned D = NUM_DIRS;

  logic [D-1:0]        sel_n, lat_n, drv_n, src_oe, drv_on;
  logic [D-1:0][W-1:0] din, q;
  lane_mode_e          mode [D];

  assign sel_n  = {ba_sel_n, ab_sel_n};
  assign lat_n  = {ba_lat_n, ab_lat_n};
  assign drv_n  = {ba_drv_n, ab_drv_n};
  assign din    = {port_b_in, port_a_in};
  // A bank's source pad is driven by the opposite bank's driver
  assign src_oe = {drv_on[0], drv_on[1]};

  for (genvar d = 0; d < D; d++) begin : g_lane
    xcvr_lane_ctrl u_ctrl (
      .rst_n      (rst_n),
      .sel_n      (sel_n[d]),
      .lat_n      (lat_n[d]),
      .drv_n      (drv_n[d]),
      .src_driven (src_oe[d]),
      .mode       (mode[d]),
      .drv_on     (drv_on[d])
    );
    xcvr_lane_store #(.W(W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode[d]),
      .din   (din[d]),
      .q     (q[d])
    );
  end

  assign port_b_out = q[0];
  assign port_b_oe  = drv_on[0];
  assign port_a_out = q[1];
  assign port_a_oe  = drv_on[1];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ab_sel_n,
  input logic         ab_lat_n,
  input logic         ab_drv_n,
  input logic         ba_sel_n,
  input logic         ba_lat_n,
  input logic         ba_drv_n,
  input logic [W-1:0] port_a_in,
  input logic [W-1:0] port_a_out,
  input logic         port_a_oe,
  input logic [W-1:0] port_b_in,
  input logic [W-1:0] port_b_out,
  input logic         port_b_oe
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (port_a_out == '0 && port_b_out == '0 && !port_a_oe && !port_b_oe)
        else $error("reset state wrong");
    end
  end

  assert_follow_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_sel_n && !ab_lat_n && !port_a_oe) |=> (port_b_out == $past(port_a_in)));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ab_lat_n |=> $stable(port_b_out));

  assert_desel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ab_sel_n |=> $stable(port_b_out));

  assert_desel_nodrive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ab_sel_n |-> !port_b_oe);

  assert_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_drv_n |-> !port_b_oe) and (ba_drv_n |-> !port_a_oe));

  assert_follow_ba_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_sel_n && !ba_lat_n && !port_b_oe) |=> (port_a_out == $past(port_b_in)));

  assert_ba_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_sel_n || ba_lat_n) |=> $stable(port_a_out));

  assert_loopback_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_a_oe |=> $stable(port_b_out)) and (port_b_oe |=> $stable(port_a_out)));
endmodule

bind bidir_latch_xcvr xcvr_checker #(.W(W)) u_xcvr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ab_sel_n   (ab_sel_n),
  .ab_lat_n   (ab_lat_n),
  .ab_drv_n   (ab_drv_n),
  .ba_sel_n   (ba_sel_n),
  .ba_lat_n   (ba_lat_n),
  .ba_drv_n   (ba_drv_n),
  .port_a_in  (port_a_in),
  .port_a_out (port_a_out),
  .port_a_oe  (port_a_oe),
  .port_b_in  (port_b_in),
  .port_b_out (port_b_out),
  .port_b_oe  (port_b_oe)
);

// File: tb/bidir_latch_xcvr_bench.sv
module bidir_latch_xcvr_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ab_sel_n = 1'b1, ab_lat_n = 1'b1, ab_drv_n = 1'b1;
  logic ba_sel_n = 1'b1, ba_lat_n = 1'b1, ba_drv_n = 1'b1;
  logic [W-1:0] a_ext = '0, b_ext = '0;
  logic [W-1:0] port_a_in, port_a_out, port_b_in, port_b_out;
  logic port_a_oe, port_b_oe;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Reference state, updated behaviourally from the requirements
  int ref_ab = 0;
  int ref_ba = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Pads loop back: a driven pad reads back its own driven value
  assign port_a_in = port_a_oe ? port_a_out : a_ext;
  assign port_b_in = port_b_oe ? port_b_out : b_ext;

  bidir_latch_xcvr #(.W(W)) u_bidir_latch_xcvr (
    .clk(clk), .rst_n(rst_n),
    .ab_sel_n(ab_sel_n), .ab_lat_n(ab_lat_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_lat_n(ba_lat_n), .ba_drv_n(ba_drv_n),
    .port_a_in(port_a_in), .port_a_out(port_a_out), .port_a_oe(port_a_oe),
    .port_b_in(port_b_in), .port_b_out(port_b_out), .port_b_oe(port_b_oe)
  );

  function automatic bit exp_a_oe();
    return rst_n && !ba_sel_n && !ba_drv_n;
  endfunction
  function automatic bit exp_b_oe();
    return rst_n && !ab_sel_n && !ab_drv_n;
  endfunction

  always @(posedge clk) begin
    int n_ab, n_ba;
    cycles++;
    n_ab = ref_ab;
    n_ba = ref_ba;
    if (!rst_n) begin
      n_ab = 0;
      n_ba = 0;
    end else begin
      if (!ab_sel_n && !ab_lat_n && !exp_a_oe()) n_ab = int'(a_ext);
      if (!ba_sel_n && !ba_lat_n && !exp_b_oe()) n_ba = int'(b_ext);
    end
    ref_ab = n_ab;
    ref_ba = n_ba;
  end

  task automatic check(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("port_b_out", int'(port_b_out), ref_ab);
    check("port_a_out", int'(port_a_out), ref_ba);
    check("port_b_oe", int'(port_b_oe), int'(exp_b_oe()));
    check("port_a_oe", int'(port_a_oe), int'(exp_a_oe()));
  end

  always @(posedge clk) begin
    if (cycles > 3000) begin
      mismatched++;
      $display("FAIL watchdog: actual=%0d cycles expected=<3000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    cur_req = "R1";
    step(3);
    rst_n = 1'b1;
    step(1);

    cur_req = "R2";  // A-to-B follows, one cycle late, not inverted
    ab_sel_n = 1'b0; ab_lat_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      a_ext = 8'(i * 37 + 5);
      step(1);
    end

    cur_req = "R3";  // capture on rising latch, then ignore A
    a_ext = 8'hA5; step(1);
    ab_lat_n = 1'b1; a_ext = 8'h3C; step(2);
    a_ext = 8'hFF; step(2);

    cur_req = "R4";  // deselected: hold whatever latch does
    ab_sel_n = 1'b1; ab_lat_n = 1'b0; a_ext = 8'h11; step(3);
    ab_lat_n = 1'b1; step(1); ab_lat_n = 1'b0; a_ext = 8'h22; step(2);
    ab_drv_n = 1'b0; step(2); ab_drv_n = 1'b1;

    cur_req = "R7";  // B-to-A mirror
    ba_sel_n = 1'b0; ba_lat_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      b_ext = 8'(i * 53 + 9);
      step(1);
    end
    b_ext = 8'h96; step(1);
    ba_lat_n = 1'b1; b_ext = 8'h01; step(2);
    ba_sel_n = 1'b1; ba_lat_n = 1'b0; b_ext = 8'h02; step(2);

    cur_req = "R8";  // park both directions, then drive both
    ab_sel_n = 1'b0; ab_lat_n = 1'b0; a_ext = 8'h5A; step(1);
    ab_lat_n = 1'b1;
    ba_sel_n = 1'b0; ba_lat_n = 1'b0; b_ext = 8'hC3; step(1);
    ba_lat_n = 1'b1; a_ext = 8'h00; b_ext = 8'hFF; step(2);
    ab_drv_n = 1'b0; ba_drv_n = 1'b0; step(4);
    a_ext = 8'h77; b_ext = 8'h88; step(2);

    cur_req = "R5";  // every select/drive combination, latches closed
    for (int c = 0; c < 16; c++) begin
      {ab_sel_n, ab_drv_n, ba_sel_n, ba_drv_n} = 4'(c);
      step(1);
    end

    cur_req = "R6";  // drive control does not affect loading
    ba_sel_n = 1'b1; ba_drv_n = 1'b1;
    ab_sel_n = 1'b0; ab_lat_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ab_drv_n = i[0];
      a_ext = 8'(i * 29 + 3);
      step(1);
    end
    ab_drv_n = 1'b1; ab_sel_n = 1'b1;

    cur_req = "R9";  // loop-back: driven pad must not reload own source bank
    ba_sel_n = 1'b0; ba_lat_n = 1'b0; b_ext = 8'h4E; step(1);
    ba_lat_n = 1'b1; ba_drv_n = 1'b0;
    ab_sel_n = 1'b0; ab_lat_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      a_ext = 8'(i * 61 + 1);
      step(1);
    end
    ba_drv_n = 1'b1; step(2);  // A pad released: bank loads a_ext again
    ab_lat_n = 1'b1; ab_drv_n = 1'b0;
    ba_lat_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      b_ext = 8'(i * 71 + 7);
      step(1);
    end
    ab_drv_n = 1'b1; step(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule